// File: doc/BRIEF.md
# I2C Serial Clock Prescaler

This block turns a fast baud-rate clock into the timing reference for an I2C master. It divides in two stages: a power-of-two predivider chosen by a 2-bit code, then a programmable 8-bit stage. The 8-bit stage adds a fixed offset of three to the programmed value and, when the digital filter is enabled, a further two. The host works out the divider values. This block only applies them.

The output is a free-running sequence of half-period ticks, plus an SCL level that toggles on each tick. Every tick is tagged with a phase strobe. The rise strobe marks the tick that drives SCL high, where the master samples SDA. The fall strobe marks the tick that drives SCL low. The mode input carries the enable, the predivider code and the filter enable. These settings and the divider value are captured only while the enable is low, so a new setting takes effect at the next enable.

Top module: `i2c_sclk_prescaler`

## Requirements
- R1: The predivider code in mode_cfg[2:1] selects a predivide P of 32 >> code: code 0 gives 32, code 1 gives 16, code 2 gives 8 and code 3 gives 4.
- R2: While enabled, the SCL period is P x 2 x (D + 3 + 2F) clock cycles, where D is the divider value and F is the filter bit. Consecutive ticks are exactly half a period apart.
- R3: The filter enable in mode_cfg[3] adds 2 to the inner term when it is 1 and has no effect when it is 0.
- R4: Every divider value from 0 to 255 on div_cfg is accepted, including both extremes, with no wrap or overflow of the half-period count.
- R5: While the enable in mode_cfg[0] is 0, the counters are held cleared, no tick or strobe is produced, and scl_level is 1 from the first clock edge at which the enable is seen low.
- R6: The predivider code, the filter bit and the divider value are captured only while the enable is 0. Changes made while the enable is 1 leave the running period unchanged and take effect at the next enable.
- R7: scl_tick is a one-cycle pulse, once per half period. scl_level changes only on a tick. scl_fall accompanies each tick that drives scl_level to 0, and scl_rise each tick that drives it to 1.
- R8: The first tick after enable is a fall tick. It appears on the (P x (D + 3 + 2F))-th clock edge, counting as edge 1 the first edge at which the enable is high.
- R9: After reset, scl_level is 1 and scl_tick, scl_rise and scl_fall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baud-rate input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cfg | input | 4 | bit 0 enable, bits [2:1] predivider code, bit 3 filter enable |
| div_cfg | input | 8 | Programmable divider value, 0 to 255 |
| scl_tick | output | 1 | One-cycle pulse at each SCL half-period boundary |
| scl_rise | output | 1 | Tick that drives SCL high (SDA sample phase) |
| scl_fall | output | 1 | Tick that drives SCL low |
| scl_level | output | 1 | Generated SCL level, idle high |

## Verification
The bench measures the enable-to-first-tick latency, the half period and the full period for all four predivider codes, with the filter on and off, at divider values 0 and 255. It then repeats these measurements on random small settings.

- A design that drops the +3 offset, the doubling or the filter term, or that reverses the code-to-predivide mapping, would produce a different cycle count.
- A design with an inner counter one bit too narrow would wrap at divider 255 and produce a much shorter period.
- A design that keeps listening to the configuration while enabled would change its period mid-run; the bench rewrites both registers during operation to catch this.
- A design that holds a stale setting after re-enable would show the wrong latency on the next enable.
- A design that resumes at the wrong phase after disable would fail the check that the first tick is a fall and the check that SCL returns high.

// File: rtl/i2c_sclk_pkg.sv
// Package: shared mode-field layout and decode for the I2C clock prescaler.
// Assumes a 4-bit mode field whose bit positions are fixed by the register
// that the controller decodes.
package i2c_sclk_pkg;

    localparam int MODE_W     = 4;
    localparam int CODE_W     = 2;
    localparam int EN_BIT     = 0;
    localparam int CODE_LO    = 1;
    localparam int FILT_BIT   = 3;
    localparam int OFFSET     = 3;  // fixed addend of the inner term
    localparam int FILT_ADD   = 2;  // addend when the filter is on

    typedef struct packed {
        logic              filt;
        logic [CODE_W-1:0] code;
    } sclk_mode_t;

    // Pull the timing fields out of the raw mode field.
    function automatic sclk_mode_t decode_mode(input logic [MODE_W-1:0] raw);
        sclk_mode_t m;
        m.filt = raw[FILT_BIT];
        m.code = raw[CODE_LO +: CODE_W];
        return m;
    endfunction

endpackage

// File: rtl/i2c_sclk_cfg_hold.sv
// Module: configuration shadow. It tracks the mode fields and the divider
// while the controller is disabled and freezes them while it is enabled.
// Assumes en is the raw enable bit, sampled on the same clock.
module i2c_sclk_cfg_hold
    import i2c_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  sclk_mode_t       mode_in,
    input  logic [DIV_W-1:0] div_in,
    output sclk_mode_t       mode_q,
    output logic [DIV_W-1:0] div_q
);

    // Shadow registers follow the inputs only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
        end else if (!en) begin
            mode_q <= mode_in;
            div_q  <= div_in;
        end
    end

    // R6: settings frozen for as long as the enable stays high
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ($stable(mode_q) && $stable(div_q)));

endmodule

// File: rtl/i2c_sclk_prediv.sv
// Module: first stage, power-of-two predivider. It emits a one-cycle strobe
// every (2**PRE_LOG >> code) cycles while run is high. Assumes that code is
// below PRE_LOG, so the predivide is at least 2.
module i2c_sclk_prediv #(
    parameter int PRE_LOG = 5,
    parameter int CODE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              strobe
);

    localparam int SPAN_W = PRE_LOG + 1;

    logic [PRE_LOG-1:0] cnt;
    logic [PRE_LOG-1:0] term;
    logic [SPAN_W-1:0]  span;

    // Terminal count = predivide - 1, with the predivide = 2**(PRE_LOG - code).
    always_comb begin
        span = SPAN_W'(1) << (PRE_LOG - 32'(code));
        term = span[PRE_LOG-1:0] - PRE_LOG'(1);
    end

    assign strobe = run && (cnt == term);

    // Free-running modulo counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_LOG'(1);
        end
    end

    // R1: predivide of at least 2, so strobes never sit back to back
    assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/i2c_sclk_halfdiv.sv
// Module: second stage. It counts (div + 3 + 2*filt) predivider strobes per
// SCL half period, toggles the SCL level and reports which phase each tick
// starts. Assumes strobe is a one-cycle pulse from the predivider.
module i2c_sclk_halfdiv
    import i2c_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             strobe,
    input  logic             filt,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             rise,
    output logic             fall,
    output logic             level
);

    localparam int CNT_W = DIV_W + 1;  // holds 2**DIV_W - 1 + OFFSET + FILT_ADD

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             last;

    // Terminal count = inner term - 1.
    always_comb begin
        term = CNT_W'(div) + CNT_W'(OFFSET - 1) + (filt ? CNT_W'(FILT_ADD) : '0);
        last = strobe && (cnt == term);
    end

    // Strobe counter plus the registered tick, phase and level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            tick  <= 1'b0;
            rise  <= 1'b0;
            fall  <= 1'b0;
            level <= 1'b1;
        end else begin
            tick <= last;
            rise <= last && !level;
            fall <= last && level;
            if (last) begin
                cnt   <= '0;
                level <= !level;
            end else if (strobe) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R7: one-cycle tick
    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R7: level moves only together with a tick while running
    assert_level_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(level)) |-> tick);
    // R7: a rise strobe leaves SCL high and never pairs with a fall
    assert_rise_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (level && tick && !fall));
    // R5: stopping forces idle-high with no tick
    assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (level && !tick && !rise && !fall));

endmodule

// File: rtl/i2c_sclk_prescaler.sv
// Module: top of the I2C serial clock prescaler. It decodes the mode field,
// shadows the configuration while disabled and chains the predivider with
// the half-period divider. Assumes a single clock domain for the mode and
// divider inputs.
module i2c_sclk_prescaler
    import i2c_sclk_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LOG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_cfg,
    input  logic [DIV_W-1:0]  div_cfg,
    output logic              scl_tick,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              scl_level
);

    logic             en;
    sclk_mode_t       mode_now;
    sclk_mode_t       mode_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_strobe;

    // Split the raw mode field into enable and timing fields.
    always_comb begin
        en       = mode_cfg[EN_BIT];
        mode_now = decode_mode(mode_cfg);
    end

    i2c_sclk_cfg_hold #(.DIV_W(DIV_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode_in (mode_now),
        .div_in  (div_cfg),
        .mode_q  (mode_q),
        .div_q   (div_q)
    );

    i2c_sclk_prediv #(.PRE_LOG(PRE_LOG), .CODE_W(CODE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .code   (mode_q.code),
        .strobe (pre_strobe)
    );

    i2c_sclk_halfdiv #(.DIV_W(DIV_W)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .strobe (pre_strobe),
        .filt   (mode_q.filt),
        .div    (div_q),
        .tick   (scl_tick),
        .rise   (scl_rise),
        .fall   (scl_fall),
        .level  (scl_level)
    );

endmodule

// File: tb/sim_i2c_sclk_prescaler.sv
// Bench: directed corner settings plus seeded random settings, checked
// against expected cycle counts computed from the requirements.
module sim_i2c_sclk_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_cfg = 4'h0;
    logic [7:0] div_cfg = 8'h00;
    logic       scl_tick, scl_rise, scl_fall, scl_level;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    i2c_sclk_prescaler u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_cfg  (mode_cfg),
        .div_cfg   (div_cfg),
        .scl_tick  (scl_tick),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_level (scl_level)
    );

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Expected clock cycles per half period (R1, R2, R3).
    function automatic int half_cycles(int code, int filt, int dv);
        return (32 >> code) * (dv + 3 + 2 * filt);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the next tick at a falling edge; report its cycle and phase.
    task automatic wait_tick(output int t, output int r, output int f, output int l);
        t = -1; r = 0; f = 0; l = 0;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (scl_tick) begin
                t = cyc; r = int'(scl_rise); f = int'(scl_fall); l = int'(scl_level);
                break;
            end
        end
    endtask

    // Program while disabled, enable, then measure latency and periods.
    task automatic run_cfg(int code, int filt, int dv);
        int c0, t1, t2, t3, r, f, l, h;
        h = half_cycles(code, filt, dv);
        @(negedge clk);
        mode_cfg = {filt[0], code[1:0], 1'b0};
        div_cfg  = dv[7:0];
        repeat (3) @(negedge clk);
        mode_cfg[0] = 1'b1;
        c0 = cyc;
        wait_tick(t1, r, f, l);
        chk("R8 first tick latency", t1 - c0, h);
        chk("R8 first tick is fall", f * 2 + r, 2);
        chk("R7 level low after fall", l, 0);
        wait_tick(t2, r, f, l);
        chk("R2/R4 half period", t2 - t1, h);
        chk("R7 rise tick with level high", r * 2 + l, 3);
        wait_tick(t3, r, f, l);
        chk("R1/R2/R3/R4 full period", t3 - t1, 2 * h);
        @(negedge clk);
        mode_cfg[0] = 1'b0;
    endtask

    initial begin
        int t1, t2, t3, c0, r, f, l, nt, nl;
        void'($urandom(32'd20931));
        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 level after reset", int'(scl_level), 1);
        chk("R9 tick/rise/fall after reset", int'({scl_tick, scl_rise, scl_fall}), 0);
        rst_n = 1'b1;

        // R5: disabled block stays idle-high with no ticks
        mode_cfg = 4'b1110; div_cfg = 8'd0;
        nt = 0; nl = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (scl_tick || scl_rise || scl_fall) nt++;
            if (!scl_level) nl++;
        end
        chk("R5 no ticks while disabled", nt, 0);
        chk("R5 level high while disabled", nl, 0);

        // Directed corners: every code, filter off/on, divider 0 and 255 (R1 R3 R4)
        for (int c = 0; c < 4; c++)
            for (int fl = 0; fl < 2; fl++) begin
                run_cfg(c, fl, 0);
                run_cfg(c, fl, 255);
            end

        // R6: changes while enabled are ignored, applied at next enable
        @(negedge clk);
        mode_cfg = 4'b0110; div_cfg = 8'd10;
        repeat (3) @(negedge clk);
        mode_cfg[0] = 1'b1;
        c0 = cyc;
        wait_tick(t1, r, f, l);
        chk("R6 baseline latency", t1 - c0, half_cycles(3, 0, 10));
        mode_cfg = 4'b1001; div_cfg = 8'd200;
        wait_tick(t2, r, f, l);
        chk("R6 half period unchanged", t2 - t1, half_cycles(3, 0, 10));
        wait_tick(t3, r, f, l);
        chk("R6 full period unchanged", t3 - t1, 2 * half_cycles(3, 0, 10));
        // R5: disable mid-run restores idle on the next edge
        @(negedge clk);
        mode_cfg[0] = 1'b0;
        @(negedge clk);
        chk("R5 idle one edge after disable", int'({scl_level, scl_tick}), 2);
        repeat (3) @(negedge clk);
        mode_cfg[0] = 1'b1;
        c0 = cyc;
        wait_tick(t1, r, f, l);
        chk("R6 new settings on next enable", t1 - c0, half_cycles(0, 1, 200));
        @(negedge clk);
        mode_cfg[0] = 1'b0;

        // Random small settings
        for (int i = 0; i < 12; i++) begin
            run_cfg(2 + int'($urandom % 2), int'($urandom % 2), int'($urandom % 40));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule